// File: doc/BRIEF.md
# Global Memory Access Coalescer

The block turns one group of parallel memory requests into the shortest run of aligned segment transactions that serves them. Each lane of the group carries an active bit and a byte address that points to a 4-byte element. When the group is accepted, the block repeats one step until every active lane has been served. The step takes the lowest-numbered lane that is still pending. It finds the aligned segment that contains that lane's address and sends one transaction for that segment. The transaction lists every pending lane whose address falls inside the segment.

A mode value is captured with the group and chooses the policy. Mode 0 serves only the lower half of the lanes. It starts from a 128-byte segment and shrinks it to 64 or 32 bytes whenever the collected lanes fit in a smaller aligned piece. Mode 1 serves all lanes and always uses 128-byte segments. Modes 2 and 3 serve all lanes and always use 32-byte segments. Both the input and the output use a valid/ready handshake. The input is ready only when no transaction is still owed for the previous group.

Top module: `mem_coalescer`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: In mode 0, lanes numbered LANES/2 and above are ignored whatever their active bits or addresses. A group whose active lanes are all in the upper half produces no transaction.
- R3: Each transaction serves the lowest-numbered pending lane. Its mask holds exactly those pending lanes whose address lies in the transaction's segment. Transactions are issued in order of their lowest-numbered lane.
- R4: In mode 0, the segment is 32 bytes if all served addresses share one aligned 32-byte block. Otherwise it is 64 bytes if they share one aligned 64-byte block. Otherwise it is 128 bytes.
- R5: out_size encodes 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. out_base is the served addresses' segment start and is aligned to the segment size.
- R6: In mode 1, every transaction is 128 bytes (out_size 2), even when fewer lanes would fit a smaller segment.
- R7: In modes 2 and 3, every transaction is 32 bytes (out_size 0), and lanes are grouped by their aligned 32-byte block.
- R8: While out_valid is 1 and out_ready is 0, out_base, out_size and out_mask hold their values into the next cycle.
- R9: After a group with at least one served lane is accepted, in_ready stays 0 until the cycle after the handshake of its last transaction. Each served lane appears in exactly one transaction.
- R10: A group with no served lanes produces no transaction, and in_ready is 1 again in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A request group is offered |
| in_ready | output | 1 | The block can accept a group |
| in_mode | input | 2 | Policy: 0 adaptive half group, 1 fixed 128 B, 2 or 3 fixed 32 B |
| in_active | input | LANES | Active bit for each lane |
| in_addr | input | LANES*ADDR_W | Byte addresses; lane i uses bits [i*ADDR_W +: ADDR_W] |
| out_valid | output | 1 | A transaction is offered |
| out_ready | input | 1 | The consumer takes the transaction |
| out_base | output | ADDR_W | Aligned segment base address |
| out_size | output | 2 | Segment size code |
| out_mask | output | LANES | Lanes served by this transaction |

## Verification
Several properties are checked on every cycle. The segment base must be aligned to the size code, and the size must fit the captured mode. Mode 0 must never serve an upper-half lane. Every mask must be a non-empty part of the pending lanes. Lanes that have been handed off must leave the pending set, an offer held under back-pressure must stay stable, and an empty group must release the input at once. Only the bench scenarios can show the exact number of transactions, their order, and the shrink decisions on real address patterns. These cover aligned and misaligned contiguous runs, a spread within one 128-byte block, interleaved blocks, fully scattered lanes and empty groups.

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_mode,
  input  logic [LANES-1:0]        in_active,
  input  logic [LANES*ADDR_W-1:0] in_addr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_base,
  output logic [1:0]              out_size,
  output logic [LANES-1:0]        out_mask
);

  localparam int HALF = LANES / 2;
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANES-1:0] LOW_HALF = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};

  logic [ADDR_W-1:0] addr_q [LANES];
  logic [LANES-1:0]  pend_q;
  logic [1:0]        mode_q;

  logic [IW-1:0]     lead;
  logic [ADDR_W-1:0] lead_addr;
  logic [LANES-1:0]  coll;
  logic              fits64, fits32;
  logic [LANES-1:0]  grp_mask;
  logic              accept, handoff;

  assign grp_mask  = (in_mode == 2'd0) ? LOW_HALF : '1;
  assign in_ready  = (pend_q == '0);
  assign out_valid = (pend_q != '0);
  assign accept    = in_valid && in_ready;
  assign handoff   = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mode_q <= 2'd0;
    end else if (accept) begin
      pend_q <= in_active & grp_mask;
      mode_q <= in_mode;
    end else if (handoff) begin
      pend_q <= pend_q & ~out_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < LANES; i++) addr_q[i] <= in_addr[i*ADDR_W +: ADDR_W];
    end
  end

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_q[i]) lead = IW'(i);
    end
  end

  assign lead_addr = addr_q[lead];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (mode_q[1])
        coll[i] = pend_q[i] && (addr_q[i][ADDR_W-1:5] == lead_addr[ADDR_W-1:5]);
      else
        coll[i] = pend_q[i] && (addr_q[i][ADDR_W-1:7] == lead_addr[ADDR_W-1:7]);
    end
  end

  always_comb begin
    fits64 = 1'b1;
    fits32 = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (coll[i] && (addr_q[i][6] != lead_addr[6])) fits64 = 1'b0;
      if (coll[i] && (addr_q[i][5] != lead_addr[5])) fits32 = 1'b0;
    end
  end

  always_comb begin
    if (mode_q[1])             out_size = 2'd0;
    else if (mode_q[0])        out_size = 2'd2;
    else if (fits64 && fits32) out_size = 2'd0;
    else if (fits64)           out_size = 2'd1;
    else                       out_size = 2'd2;
  end

  assign out_base = lead_addr & ~((ADDR_W'(1) << (5 + out_size)) - ADDR_W'(1));
  assign out_mask = coll;

  a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_base) && $stable(out_size) && $stable(out_mask));

  a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_base[4:0] == 5'd0 && out_size != 2'd3 &&
                  (out_size == 2'd0 || !out_base[5]) && (out_size != 2'd2 || !out_base[6]));

  a_r2_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == 2'd0 |-> (out_mask & ~LOW_HALF) == '0);

  a_r6_fixed_large: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q == 2'd1 |-> out_size == 2'd2);

  a_r7_fixed_small: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && mode_q[1] |-> out_size == 2'd0);

  a_r3_mask_subset: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mask != '0 && (out_mask & ~pend_q) == '0);

  a_r9_lanes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> (pend_q & $past(out_mask)) == '0);

  a_r10_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_active & grp_mask) == '0 |=> in_ready && !out_valid);

endmodule

// File: tb/sim_mem_coalescer.sv
module sim_mem_coalescer;
  logic              clk = 0;
  logic              rst_n = 0;
  logic              in_valid = 0;
  logic              in_ready;
  logic [1:0]        in_mode = 0;
  logic [31:0]       in_active = 0;
  logic [1023:0]     in_addr;
  logic              out_valid;
  logic              out_ready = 0;
  logic [31:0]       out_base;
  logic [1:0]        out_size;
  logic [31:0]       out_mask;
  logic [31:0]       addr_arr [32];

  int checks = 0;
  int errors = 0;
  int n_tx;
  int last_cyc;
  logic [31:0] t_base [64];
  logic [1:0]  t_size [64];
  logic [31:0] t_mask [64];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 32; i++) in_addr[i*32 +: 32] = addr_arr[i];
  end

  mem_coalescer #(.LANES(32), .ADDR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_active(in_active), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_base(out_base),
    .out_size(out_size), .out_mask(out_mask));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [31:0] act, input int stall);
    int cyc;
    bit acc;
    bit hold;
    logic [31:0] hb, hm;
    logic [1:0] hs;
    n_tx = 0; acc = 0; cyc = 0; hold = 0;
    @(negedge clk);
    in_mode = m; in_active = act; in_valid = 1;
    forever begin
      out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      #1;
      if (acc) begin
        if (in_ready && !out_valid) break;
      end
      if (hold) begin
        chk(out_valid && out_base == hb && out_size == hs && out_mask == hm,
            "R8", "held offer", {30'd0, out_size, out_base}, {30'd0, hs, hb});
        hold = 0;
      end
      if (out_valid && out_ready) begin
        if (n_tx < 64) begin
          t_base[n_tx] = out_base; t_size[n_tx] = out_size; t_mask[n_tx] = out_mask;
        end
        n_tx++;
      end else if (out_valid) begin
        hold = 1; hb = out_base; hs = out_size; hm = out_mask;
      end
      if (!acc && in_ready) acc = 1;
      @(negedge clk);
      if (acc) in_valid = 0;
      cyc++;
      if (cyc > 2000) begin
        chk(0, "R9", "watchdog", cyc, 0);
        break;
      end
    end
    last_cyc = cyc;
  endtask

  task automatic exp_tx(input int k, input logic [31:0] b, input logic [1:0] s,
                        input logic [31:0] msk, input string req);
    chk(t_base[k] == b, req, $sformatf("tx%0d base", k), t_base[k], b);
    chk(t_size[k] == s, req, $sformatf("tx%0d size", k), t_size[k], s);
    chk(t_mask[k] == msk, req, $sformatf("tx%0d mask", k), t_mask[k], msk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_adapt_aligned;
    for (int i = 0; i < 32; i++) addr_arr[i] = (i < 16) ? 32'h1000 + 4*i : 32'h9000 + 4*i;
    run(2'd0, 32'hFFFF_FFFF, 0);
    chk(n_tx == 1, "R4", "aligned 64B run count", n_tx, 1);
    exp_tx(0, 32'h1000, 2'd1, 32'h0000_FFFF, "R2");
    chk(last_cyc == 2, "R9", "input released after last handoff", last_cyc, 2);
  endtask

  task automatic t_adapt_misaligned;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h1070 + 4*i;
    run(2'd0, 32'h0000_FFFF, 3);
    chk(n_tx == 2, "R4", "64+32 split count", n_tx, 2);
    exp_tx(0, 32'h1060, 2'd0, 32'h0000_000F, "R3");
    exp_tx(1, 32'h1080, 2'd1, 32'h0000_FFF0, "R4");
  endtask

  task automatic t_adapt_spread;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h2000 + 8*i;
    run(2'd0, 32'h0000_FFFF, 0);
    chk(n_tx == 1, "R4", "spread count", n_tx, 1);
    exp_tx(0, 32'h2000, 2'd2, 32'h0000_FFFF, "R4");
  endtask

  task automatic t_adapt_interleave;
    for (int i = 0; i < 32; i++) addr_arr[i] = (i % 2 == 0) ? 32'h3000 + 4*i : 32'h5000 + 4*i;
    run(2'd0, 32'h0000_FFFF, 2);
    chk(n_tx == 2, "R3", "interleave count", n_tx, 2);
    exp_tx(0, 32'h3000, 2'd1, 32'h0000_5555, "R3");
    exp_tx(1, 32'h5000, 2'd1, 32'h0000_AAAA, "R3");
  endtask

  task automatic t_adapt_single;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h7FFC;
    run(2'd0, 32'h0000_0020, 0);
    chk(n_tx == 1, "R5", "single lane count", n_tx, 1);
    exp_tx(0, 32'h7FE0, 2'd0, 32'h0000_0020, "R5");
  endtask

  task automatic t_fixed128;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h1000 + 4*i;
    run(2'd1, 32'hFFFF_FFFF, 0);
    chk(n_tx == 1, "R6", "full 128B count", n_tx, 1);
    exp_tx(0, 32'h1000, 2'd2, 32'hFFFF_FFFF, "R6");
    addr_arr[0] = 32'h1004; addr_arr[1] = 32'h1008;
    run(2'd1, 32'h0000_0003, 0);
    chk(n_tx == 1, "R6", "no shrink count", n_tx, 1);
    exp_tx(0, 32'h1000, 2'd2, 32'h0000_0003, "R6");
  endtask

  task automatic t_fixed32;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h1000 + 4*i;
    run(2'd2, 32'hFFFF_FFFF, 0);
    chk(n_tx == 4, "R7", "contiguous 32B count", n_tx, 4);
    for (int k = 0; k < 4; k++)
      exp_tx(k, 32'h1000 + 32*k, 2'd0, 32'hFF << (8*k), "R7");
  endtask

  task automatic t_scattered;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h10000 + 256*i + 12;
    run(2'd2, 32'hFFFF_FFFF, 2);
    chk(n_tx == 32, "R7", "scattered count", n_tx, 32);
    for (int k = 0; k < 32; k++)
      exp_tx(k, 32'h10000 + 256*k, 2'd0, 32'h1 << k, "R7");
  endtask

  task automatic t_mode3;
    for (int i = 0; i < 32; i++) addr_arr[i] = 32'h40 + 4*i;
    run(2'd3, 32'h0000_0003, 0);
    chk(n_tx == 1, "R7", "mode 3 count", n_tx, 1);
    exp_tx(0, 32'h40, 2'd0, 32'h0000_0003, "R7");
  endtask

  task automatic t_empty;
    run(2'd1, 32'h0, 0);
    chk(n_tx == 0, "R10", "empty group tx", n_tx, 0);
    chk(last_cyc == 1, "R10", "empty group release", last_cyc, 1);
    run(2'd0, 32'hFFFF_0000, 0);
    chk(n_tx == 0, "R2", "upper half only tx", n_tx, 0);
    chk(last_cyc == 1, "R2", "upper half only release", last_cyc, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) addr_arr[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_adapt_aligned;
    t_adapt_misaligned;
    t_adapt_spread;
    t_adapt_interleave;
    t_adapt_single;
    t_fixed128;
    t_fixed32;
    t_scattered;
    t_mode3;
    t_empty;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL R9 watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule